// File: doc/BRIEF.md
# Double-Buffered Serial Data Register

This block is the byte data path of a two-wire serial bus interface. The CPU sees it as one 8-bit port. A write always fills a transmit holding buffer, and a read always returns a receive holding buffer. Behind the port, a shift register moves bits to and from the line, one bit for each shift strobe. When the bus framer pulses frame-complete, the block moves data between the holding buffers and the shift register on its own. The transfer direction depends on the mode input. Two flags tell the CPU when it can write the next byte and when a received byte is waiting.

Frames may carry 1 to 8 bits, and either bit order can be selected. Shifting is always toward the end that sends first. Because of this, a short transmit byte is justified toward the end that sends first, and a short received byte lands at the opposite end. Received bit positions that the frame did not fill read as zero.

Top module: `serdata_dbuf`

## Requirements
- R1: After reset, `txEmpty` is 1, `rxFull` is 0, `cpuRdData` is 0 and `serOut` is 0.
- R2: A cycle with `cpuWrEn` high stores `cpuWrData` in the transmit buffer, and `txEmpty` reads 0 after that edge.
- R3: With `txMode`=1 (transmit), a `frameDone` pulse while `txEmpty`=0 copies the transmit buffer into the shift register and sets `txEmpty` back to 1.
- R4: With `txMode`=0 (receive), a `frameDone` pulse while `rxFull`=0 copies the received bits into the receive buffer and sets `rxFull`.
- R5: `txEmpty` never rises while in receive mode, and `rxFull` never rises while in transmit mode.
- R6: `cpuRdData` always shows the receive buffer, in either mode and never the shift register. A cycle with `cpuRdEn` high clears `rxFull`.
- R7: With `lsbFirst`=0, `serOut` is shift register bit 7 and each `shiftStb` shifts left, taking `serIn` into bit 0. An n-bit transmit byte therefore goes out from bit 7 down to bit 8-n (MSB-justified), and an n-bit received byte reads in bits n-1..0 with the first bit most significant (LSB-justified).
- R8: With `lsbFirst`=1, `serOut` is shift register bit 0 and each `shiftStb` shifts right, taking `serIn` into bit 7. An n-bit transmit byte goes out from bit 0 up to bit n-1 (LSB-justified), and the k-th received bit (k from 0) reads at bit 8-n+k (MSB-justified).
- R9: `frameBits` gives n. Received bit positions outside the n filled ones read as 0, and values of 0 or above 8 are taken as 8.
- R10: If a receive frame completes while `rxFull`=1, the shift register keeps its bits. They move to the receive buffer on the first edge after a read has cleared `rxFull`.
- R11: If a transmit frame completes while `txEmpty`=1, the shift register and `serOut` keep their values. The next write is loaded into the shift register one edge after it reaches the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWrEn | input | 1 | CPU write strobe into the transmit buffer |
| cpuWrData | input | 8 | CPU write data |
| cpuRdEn | input | 1 | CPU read strobe; clears the receive-full flag |
| cpuRdData | output | 8 | Receive buffer contents |
| txMode | input | 1 | 1 = transmit, 0 = receive |
| lsbFirst | input | 1 | 1 = LSB first, 0 = MSB first |
| frameBits | input | 4 | Bits per frame, 1 to 8 |
| shiftStb | input | 1 | Shift the register by one bit |
| serIn | input | 1 | Serial bit shifted in |
| serOut | output | 1 | Serial bit currently presented |
| frameDone | input | 1 | One-cycle frame-complete pulse |
| txEmpty | output | 1 | Transmit buffer may be written |
| rxFull | output | 1 | Receive buffer holds unread data |

## Verification
The properties assume that the framer never raises `shiftStb` and `frameDone` in the same cycle. They also assume it does not shift while a received frame is still waiting for a free receive buffer. The line-hold property in transmit mode further assumes that no write coincides with the observed cycle. The bench keeps within these assumptions. Each strobe is a separate one-cycle pulse issued from a task. In the overrun case, the bench reads the buffer before it shifts any new bits in.

// File: rtl/serdata_pkg.sv
package serdata_pkg;
  // Strobes from the control to the datapath, one-cycle each
  typedef struct packed {
    logic wrTx;    // CPU byte into transmit buffer
    logic txToSh;  // transmit buffer into shift register
    logic shToRx;  // shift register (masked) into receive buffer
    logic shift;   // one bit step of the shift register
  } ctrlStb_t;
endpackage

// File: rtl/serdata_ctrl.sv
module serdata_ctrl
  import serdata_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cpuWrEn,
  input  logic     cpuRdEn,
  input  logic     txMode,
  input  logic     shiftStb,
  input  logic     frameDone,
  output ctrlStb_t stb,
  output logic     txEmpty,
  output logic     rxFull
);
  logic txPend;  // transmit frame ended with nothing to reload
  logic rxPend;  // receive frame ended with receive buffer occupied

  always_comb begin
    stb.wrTx   = cpuWrEn;
    stb.txToSh = txMode && !txEmpty && (frameDone || txPend);
    stb.shToRx = !txMode && !rxFull && (frameDone || rxPend);
    stb.shift  = shiftStb && !stb.txToSh && !stb.shToRx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEmpty <= 1'b1;
      rxFull  <= 1'b0;
      txPend  <= 1'b0;
      rxPend  <= 1'b0;
    end else begin
      // transmit side: a write wins over a same-cycle reload
      if (cpuWrEn)         txEmpty <= 1'b0;
      else if (stb.txToSh) txEmpty <= 1'b1;

      // receive side: a load wins over a same-cycle read
      if (stb.shToRx)   rxFull <= 1'b1;
      else if (cpuRdEn) rxFull <= 1'b0;

      if (!txMode || stb.txToSh)     txPend <= 1'b0;
      else if (frameDone && txEmpty) txPend <= 1'b1;

      if (txMode || stb.shToRx)     rxPend <= 1'b0;
      else if (frameDone && rxFull) rxPend <= 1'b1;
    end
  end
endmodule

// File: rtl/serdata_dpath.sv
module serdata_dpath
  import serdata_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              lsbFirst,
  input  logic [CNT_W-1:0]  frameBits,
  input  logic              serIn,
  output logic              serOut,
  output logic [DATA_W-1:0] rxBuf
);
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] txBuf;
  logic [DATA_W-1:0] rxMask;
  logic [CNT_W-1:0]  effBits;

  // out-of-range counts mean a full byte
  always_comb begin
    effBits = frameBits;
    if (frameBits == '0 || frameBits > CNT_W'(DATA_W)) effBits = CNT_W'(DATA_W);
  end

  // received bits sit at the low end (MSB first) or the high end (LSB first)
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      always_comb begin
        if (lsbFirst) rxMask[i] = (CNT_W'(DATA_W - i) <= effBits);
        else          rxMask[i] = (CNT_W'(i) < effBits);
      end
    end
  endgenerate

  assign serOut = lsbFirst ? shReg[0] : shReg[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
      txBuf <= '0;
      rxBuf <= '0;
    end else begin
      if (stb.wrTx) txBuf <= cpuWrData;
      if (stb.txToSh) shReg <= txBuf;
      else if (stb.shift) begin
        if (lsbFirst) shReg <= {serIn, shReg[DATA_W-1:1]};
        else          shReg <= {shReg[DATA_W-2:0], serIn};
      end
      if (stb.shToRx) rxBuf <= shReg & rxMask;
    end
  end
endmodule

// File: rtl/serdata_dbuf.sv
module serdata_dbuf
  import serdata_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuRdEn,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic              txMode,
  input  logic              lsbFirst,
  input  logic [CNT_W-1:0]  frameBits,
  input  logic              shiftStb,
  input  logic              serIn,
  output logic              serOut,
  input  logic              frameDone,
  output logic              txEmpty,
  output logic              rxFull
);
  ctrlStb_t stb;

  serdata_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn),
    .txMode(txMode), .shiftStb(shiftStb), .frameDone(frameDone),
    .stb(stb), .txEmpty(txEmpty), .rxFull(rxFull)
  );

  serdata_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cpuWrData(cpuWrData),
    .lsbFirst(lsbFirst), .frameBits(frameBits), .serIn(serIn),
    .serOut(serOut), .rxBuf(cpuRdData)
  );
endmodule

// File: rtl/serdata_dbuf_chk.sv
module serdata_dbuf_chk (
  input logic clk,
  input logic rstN,
  input logic cpuWrEn,
  input logic cpuRdEn,
  input logic txMode,
  input logic shiftStb,
  input logic frameDone,
  input logic serOut,
  input logic txEmpty,
  input logic rxFull
);
  p_write_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuWrEn |=> !txEmpty);

  p_tx_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txMode && frameDone && !txEmpty && !cpuWrEn) |=> txEmpty);

  p_rx_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!txMode && frameDone && !rxFull) |=> rxFull);

  p_tx_rise_dir_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEmpty) |-> $past(txMode));

  p_rx_rise_dir_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> !$past(txMode));

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdEn && txMode) |=> !rxFull);

  p_overrun_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!txMode && rxFull && frameDone && !cpuRdEn) |=> rxFull);

  p_line_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (txMode && txEmpty && !shiftStb && !cpuWrEn) |=> $stable(serOut));
endmodule

bind serdata_dbuf serdata_dbuf_chk uChkBind (
  .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn),
  .txMode(txMode), .shiftStb(shiftStb), .frameDone(frameDone),
  .serOut(serOut), .txEmpty(txEmpty), .rxFull(rxFull)
);

// File: tb/serdata_dbuf_test.sv
module serdata_dbuf_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuWrEn = 1'b0, cpuRdEn = 1'b0;
  logic [7:0] cpuWrData = '0;
  logic [7:0] cpuRdData;
  logic       txMode = 1'b1, lsbFirst = 1'b0;
  logic [3:0] frameBits = 4'd8;
  logic       shiftStb = 1'b0, serIn = 1'b0, frameDone = 1'b0;
  logic       serOut, txEmpty, rxFull;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serdata_dbuf uut (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuWrData(cpuWrData),
    .cpuRdEn(cpuRdEn), .cpuRdData(cpuRdData), .txMode(txMode),
    .lsbFirst(lsbFirst), .frameBits(frameBits), .shiftStb(shiftStb),
    .serIn(serIn), .serOut(serOut), .frameDone(frameDone),
    .txEmpty(txEmpty), .rxFull(rxFull)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cpuWrite(input logic [7:0] d);
    cpuWrData = d; cpuWrEn = 1'b1; tick(); cpuWrEn = 1'b0;
  endtask

  task automatic cpuRead(output logic [7:0] d);
    d = cpuRdData; cpuRdEn = 1'b1; tick(); cpuRdEn = 1'b0;
  endtask

  task automatic pulseFrame();
    frameDone = 1'b1; tick(); frameDone = 1'b0;
  endtask

  task automatic shiftBit(input logic b);
    serIn = b; shiftStb = 1'b1; tick(); shiftStb = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd, pat, exp, dat;
    logic [7:0] vals [4];
    vals[0] = 8'hA5; vals[1] = 8'h3C; vals[2] = 8'hFF; vals[3] = 8'h81;

    tick(); tick(); rstN = 1'b1; tick();
    // R1 reset state
    chk("R1 txEmpty", int'(txEmpty), 1);
    chk("R1 rxFull", int'(rxFull), 0);
    chk("R1 rdData", int'(cpuRdData), 0);
    chk("R1 serOut", int'(serOut), 0);

    // near-exhaustive sweep: order x length x data, both directions
    for (int o = 0; o < 2; o++) begin
      for (int n = 1; n <= 8; n++) begin
        for (int v = 0; v < 4; v++) begin
          lsbFirst = o[0]; frameBits = 4'(n);
          // transmit: R2 R3 R7 R8
          txMode = 1'b1; dat = vals[v];
          cpuWrite(dat);
          chk("R2 txEmpty after write", int'(txEmpty), 0);
          pulseFrame();
          chk("R3 txEmpty after reload", int'(txEmpty), 1);
          for (int i = 0; i < n; i++) begin
            chk(o ? "R8 tx bit" : "R7 tx bit", int'(serOut),
                int'(o ? dat[i] : dat[7-i]));
            shiftBit(1'b0);
          end
          // receive: R4 R6 R7 R8 R9
          txMode = 1'b0; pat = vals[v] ^ 8'h5A; exp = '0;
          for (int i = 0; i < n; i++) begin
            shiftBit(pat[i]);
            if (o == 0) exp = {exp[6:0], pat[i]};
            else exp[8-n+i] = pat[i];
          end
          pulseFrame();
          chk("R4 rxFull after frame", int'(rxFull), 1);
          cpuRead(rd);
          chk(o ? "R8 R9 rx data" : "R7 R9 rx data", int'(rd), int'(exp));
          chk("R6 rxFull after read", int'(rxFull), 0);
        end
      end
    end

    // R9 out-of-range count means 8 bits
    lsbFirst = 1'b0; frameBits = 4'd0; txMode = 1'b0;
    for (int i = 0; i < 8; i++) shiftBit(8'hC6 >> (7 - i));
    pulseFrame(); cpuRead(rd);
    chk("R9 frameBits=0 as 8", int'(rd), 'hC6);
    frameBits = 4'd8;

    // R5 no transmit reload in receive mode
    cpuWrite(8'h96);
    pulseFrame();
    chk("R5 txEmpty held in rx mode", int'(txEmpty), 0);
    // R6 read in transmit mode returns receive buffer
    txMode = 1'b1;
    chk("R6 rdData in tx mode", int'(cpuRdData), 'hC6);
    cpuRead(rd);
    chk("R6 rxFull cleared in tx mode", int'(rxFull), 0);
    // R5 no receive load in transmit mode
    pulseFrame();
    chk("R5 rxFull held in tx mode", int'(rxFull), 0);
    chk("R3 serOut from reload", int'(serOut), 1);

    // R11 transmit underrun: hold, then reload on write
    pulseFrame();
    chk("R11 serOut held", int'(serOut), 1);
    chk("R11 txEmpty stays", int'(txEmpty), 1);
    cpuWrite(8'h40);
    chk("R11 txEmpty after write", int'(txEmpty), 0);
    tick();
    chk("R11 txEmpty after late reload", int'(txEmpty), 1);
    chk("R11 serOut after late reload", int'(serOut), 0);
    shiftBit(1'b0);
    chk("R11 second bit", int'(serOut), 1);

    // R10 receive overrun: hold, then retry after read
    txMode = 1'b0;
    for (int i = 0; i < 8; i++) shiftBit(8'h3A >> (7 - i));
    pulseFrame();
    for (int i = 0; i < 8; i++) shiftBit(8'hE1 >> (7 - i));
    pulseFrame();
    chk("R10 rxFull held", int'(rxFull), 1);
    cpuRead(rd);
    chk("R10 first byte", int'(rd), 'h3A);
    chk("R10 rxFull after read", int'(rxFull), 0);
    tick();
    chk("R10 rxFull after retry", int'(rxFull), 1);
    cpuRead(rd);
    chk("R10 held byte", int'(rd), 'hE1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule